// File: doc/BRIEF.md
# Pipelined Logarithmic Barrel Shifter

This block moves a 32-bit operand by any distance from 0 to 31 places in either direction. It covers three kinds of operation: a logical shift that fills with zeros, an arithmetic right shift that fills with copies of the sign bit, and a rotation that wraps bits around the word. Each stage is a row of two-input multiplexers. One bit of the distance steers each stage. The stages are ordered from the largest binary weight down to the smallest, and a register follows each stage. A fresh operand can be accepted on every clock. Its result leaves the block a fixed number of clocks later, together with a copy of its valid strobe.

Every operation is carried out as a move toward the low end of the word. A leftward logical shift mirrors the operand at the input and mirrors the result back at the output. A leftward rotation by N is performed as a rightward rotation by (32 − N) mod 32. The fill bit, the rotate flag, the mirror flag and the distance bits still to be used all travel down the pipeline beside their operand. Operands of different kinds can therefore follow one another with no gap.

Top module: `log_shift_pipe`

## Requirements
- R1: With `in_mode` = 2'b00 and `in_dir` = 0 (left), the result is `in_data` shifted toward bit 31 by `in_amt` places, and the vacated low bits are zero.
- R2: With `in_mode` = 2'b00 and `in_dir` = 1 (right), the result is `in_data` shifted toward bit 0 by `in_amt` places, and the vacated high bits are zero.
- R3: With `in_mode` = 2'b01 and `in_dir` = 1, the vacated high bits are copies of `in_data[31]`. With `in_mode` = 2'b01 and `in_dir` = 0, the result equals the logical left shift.
- R4: With `in_mode` = 2'b10, bits leaving one end of the word re-enter at the other end. A left rotate by N equals a right rotate by (32 − N) mod 32.
- R5: An `in_amt` of 0 returns `in_data` unchanged in every mode and in both directions.
- R6: The result of an operand sampled at clock edge k is on `out_data` after edge k+5. Operands can be sampled on consecutive edges with any mix of modes and directions, and each gets its own result.
- R7: `out_valid` repeats `in_valid` five edges later. A clock edge with `rst_n` low clears every valid flag in the pipeline, so no result is flagged for an operand sampled before that edge.
- R8: The reserved `in_mode` value 2'b11 behaves exactly like 2'b00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low; clears the valid flags |
| in_valid | input | 1 | Operand on the inputs is to be processed this cycle |
| in_data | input | 32 | Operand word |
| in_amt | input | 5 | Shift or rotate distance, 0 to 31 |
| in_dir | input | 1 | 0 moves toward bit 31 (left), 1 toward bit 0 (right) |
| in_mode | input | 2 | 00 logical, 01 arithmetic, 10 rotate, 11 treated as logical |
| out_valid | output | 1 | `out_data` carries a result |
| out_data | output | 32 | Result word |

## Verification
The bench builds the block with its default width of 32, which gives five multiplexer stages and five pipeline registers. With this width, distances of 16 and 1 exercise a single stage each. A distance of 31 drives all five stages at once, and a distance of 0 leaves every stage in pass-through. A pseudo-random stream with idle gaps mixes all modes and directions back to back. This shows that the control bits stay aligned with their own operand at every stage.

// File: rtl/bsh_pkg.sv
// Shared definitions for the pipelined barrel shifter.
// Assumes the mode field is two bits wide; the value 2'b11 is reserved.
package bsh_pkg;

    typedef enum logic [1:0] {
        MODE_LOGIC = 2'b00,
        MODE_ARITH = 2'b01,
        MODE_ROT   = 2'b10,
        MODE_RSVD  = 2'b11
    } shift_mode_e;

endpackage

// File: rtl/bsh_bitrev.sv
// Optional bit-order mirror: q is d with its bit order reversed when en is
// high, and d unchanged otherwise. Purely combinational.
module bsh_bitrev #(
    parameter int WIDTH = 32
) (
    input  logic             en,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] mirrored;

    // Wire each output bit to its mirror position.
    for (genvar i = 0; i < WIDTH; i++) begin : g_mir
        assign mirrored[i] = d[WIDTH-1-i];
    end

    // Select mirrored or straight order.
    assign q = en ? mirrored : d;

endmodule

// File: rtl/bsh_prep.sv
// Input recoding: turns every request into a rightward move.
// Left shifts are mirrored; left rotates become right rotates by the
// complementary distance. Assumes WIDTH is a power of two.
module bsh_prep
    import bsh_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int AMT_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] in_data,
    input  logic [AMT_W-1:0] in_amt,
    input  logic             in_dir,
    input  logic [1:0]       in_mode,
    output logic [WIDTH-1:0] core_data,
    output logic [AMT_W-1:0] core_amt,
    output logic             core_fill,
    output logic             core_rot,
    output logic             core_rev
);

    logic is_rot;
    logic is_arith;
    logic [AMT_W-1:0] amt_cmpl;

    // Decode the mode field.
    assign is_rot   = (shift_mode_e'(in_mode) == MODE_ROT);
    assign is_arith = (shift_mode_e'(in_mode) == MODE_ARITH);

    // Complement distance modulo the word size for left rotates.
    assign amt_cmpl = '0 - in_amt;

    // Mirror only left shifts (rotates are handled by distance recoding).
    assign core_rev  = !in_dir && !is_rot;
    assign core_rot  = is_rot;
    assign core_fill = in_dir && is_arith && in_data[WIDTH-1];
    assign core_amt  = (is_rot && !in_dir) ? amt_cmpl : in_amt;

    bsh_bitrev #(.WIDTH(WIDTH)) u_in_mirror (
        .en (core_rev),
        .d  (in_data),
        .q  (core_data)
    );

endmodule

// File: rtl/bsh_ctrl_pipe.sv
// Control delay network: hands each stage the control bits of the operand
// it is currently holding. Distance bit b is consumed by stage AMT_W-1-b and
// is delayed that many clocks; fill and rotate flags are tapped per stage;
// the mirror flag is delayed through the whole pipeline. Assumes AMT_W >= 2.
module bsh_ctrl_pipe #(
    parameter int AMT_W = 5
) (
    input  logic             clk,
    input  logic [AMT_W-1:0] amt_in,
    input  logic             fill_in,
    input  logic             rot_in,
    input  logic             rev_in,
    output logic [AMT_W-1:0] sel_at,
    output logic [AMT_W-1:0] fill_at,
    output logic [AMT_W-1:0] rot_at,
    output logic             rev_out
);

    logic [AMT_W-2:0] fill_q;
    logic [AMT_W-2:0] rot_q;
    logic [AMT_W-1:0] rev_q;

    // Per-stage distance bit, delayed by the stage index.
    for (genvar s = 0; s < AMT_W; s++) begin : g_sel
        if (s == 0) begin : g_now
            assign sel_at[0] = amt_in[AMT_W-1];
        end else begin : g_late
            logic [s-1:0] dl;
            // Delay line for this distance bit.
            always_ff @(posedge clk) begin
                dl[0] <= amt_in[AMT_W-1-s];
                for (int j = 1; j < s; j++) dl[j] <= dl[j-1];
            end
            assign sel_at[s] = dl[s-1];
        end
    end

    // Fill, rotate and mirror flags advance one stage per clock.
    always_ff @(posedge clk) begin
        fill_q[0] <= fill_in;
        rot_q[0]  <= rot_in;
        rev_q[0]  <= rev_in;
        for (int k = 1; k < AMT_W-1; k++) begin
            fill_q[k] <= fill_q[k-1];
            rot_q[k]  <= rot_q[k-1];
        end
        for (int k = 1; k < AMT_W; k++) rev_q[k] <= rev_q[k-1];
    end

    assign fill_at = {fill_q, fill_in};
    assign rot_at  = {rot_q, rot_in};
    assign rev_out = rev_q[AMT_W-1];

endmodule

// File: rtl/bsh_layer.sv
// One multiplexer stage: conditionally moves the word SHIFT places toward
// bit 0, feeding vacated positions from the far end (rotate) or with the
// fill bit, then registers the result. Only the valid flag is reset.
module bsh_layer #(
    parameter int WIDTH = 32,
    parameter int SHIFT = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             v_in,
    input  logic [WIDTH-1:0] d_in,
    input  logic             sel,
    input  logic             fill,
    input  logic             rot,
    output logic             v_q,
    output logic [WIDTH-1:0] d_q
);

    logic [WIDTH-1:0] nxt;

    // Two-input multiplexer per bit position.
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        if (i + SHIFT < WIDTH) begin : g_inside
            assign nxt[i] = sel ? d_in[i+SHIFT] : d_in[i];
        end else begin : g_edge
            assign nxt[i] = sel ? (rot ? d_in[i+SHIFT-WIDTH] : fill) : d_in[i];
        end
    end

    // Stage data register.
    always_ff @(posedge clk) begin
        d_q <= nxt;
    end

    // Stage valid register, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) v_q <= 1'b0;
        else        v_q <= v_in;
    end

endmodule

// File: rtl/log_shift_pipe.sv
// Pipelined logarithmic barrel shifter, top level.
// Recodes the request into a rightward move, runs it through AMT_W
// registered multiplexer stages (weights WIDTH/2 down to 1) and undoes the
// input mirror on the way out. Latency is AMT_W clocks, throughput one
// operand per clock. Assumes DATA_W is a power of two, at least 4.
module log_shift_pipe #(
    parameter int DATA_W = 32,
    localparam int AMT_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic [AMT_W-1:0]  in_amt,
    input  logic              in_dir,
    input  logic [1:0]        in_mode,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);

    logic [DATA_W-1:0] core_data;
    logic [AMT_W-1:0]  core_amt;
    logic              core_fill;
    logic              core_rot;
    logic              core_rev;

    logic [AMT_W-1:0]  sel_at;
    logic [AMT_W-1:0]  fill_at;
    logic [AMT_W-1:0]  rot_at;
    logic              rev_out;

    logic [DATA_W-1:0] stg_d [AMT_W+1];
    logic [AMT_W:0]    stg_v;

    bsh_prep #(.WIDTH(DATA_W), .AMT_W(AMT_W)) u_prep (
        .in_data   (in_data),
        .in_amt    (in_amt),
        .in_dir    (in_dir),
        .in_mode   (in_mode),
        .core_data (core_data),
        .core_amt  (core_amt),
        .core_fill (core_fill),
        .core_rot  (core_rot),
        .core_rev  (core_rev)
    );

    bsh_ctrl_pipe #(.AMT_W(AMT_W)) u_ctrl (
        .clk     (clk),
        .amt_in  (core_amt),
        .fill_in (core_fill),
        .rot_in  (core_rot),
        .rev_in  (core_rev),
        .sel_at  (sel_at),
        .fill_at (fill_at),
        .rot_at  (rot_at),
        .rev_out (rev_out)
    );

    assign stg_d[0] = core_data;
    assign stg_v[0] = in_valid;

    // Cascade of stages, largest weight first.
    for (genvar k = 0; k < AMT_W; k++) begin : g_stage
        bsh_layer #(.WIDTH(DATA_W), .SHIFT(1 << (AMT_W-1-k))) u_layer (
            .clk   (clk),
            .rst_n (rst_n),
            .v_in  (stg_v[k]),
            .d_in  (stg_d[k]),
            .sel   (sel_at[k]),
            .fill  (fill_at[k]),
            .rot   (rot_at[k]),
            .v_q   (stg_v[k+1]),
            .d_q   (stg_d[k+1])
        );
    end

    bsh_bitrev #(.WIDTH(DATA_W)) u_out_mirror (
        .en (rev_out),
        .d  (stg_d[AMT_W]),
        .q  (out_data)
    );

    assign out_valid = stg_v[AMT_W];

endmodule

// File: rtl/log_shift_pipe_chk.sv
// Assertion checker for log_shift_pipe, attached by bind. Keeps its own
// delayed copies of the request so each result can be related to the
// operand that produced it.
module log_shift_pipe_chk #(
    parameter int DATA_W = 32,
    localparam int AMT_W = $clog2(DATA_W),
    localparam int LAT   = AMT_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [DATA_W-1:0] in_data,
    input logic [AMT_W-1:0]  in_amt,
    input logic              in_dir,
    input logic [1:0]        in_mode,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data
);

    logic [LAT-1:0]    vd;
    logic [DATA_W-1:0] dd [LAT];
    logic [1:0]        md [LAT];
    logic [LAT-1:0]    rd;
    logic [LAT-1:0]    zd;

    // Delayed valid, cleared by reset like the design.
    always_ff @(posedge clk) begin
        if (!rst_n) vd <= '0;
        else        vd <= {vd[LAT-2:0], in_valid};
    end

    // Delayed request fields.
    always_ff @(posedge clk) begin
        dd[0] <= in_data;
        md[0] <= in_mode;
        rd[0] <= in_dir;
        zd[0] <= (in_amt == '0);
        for (int k = 1; k < LAT; k++) begin
            dd[k] <= dd[k-1];
            md[k] <= md[k-1];
            rd[k] <= rd[k-1];
            zd[k] <= zd[k-1];
        end
    end

    // R7: valid reappears exactly LAT clocks later
    a_r7_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == vd[LAT-1]);

    // R7: a reset edge leaves no flagged result
    a_r7_reset_clears: assert property (@(posedge clk)
        !rst_n |=> !out_valid);

    // R5: zero distance is a pass-through
    a_r5_zero_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && zd[LAT-1]) |-> (out_data == dd[LAT-1]));

    // R4: rotation preserves the number of set bits
    a_r4_rot_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && md[LAT-1] == 2'b10) |-> ($countones(out_data) == $countones(dd[LAT-1])));

    // R3: arithmetic right keeps the sign bit
    a_r3_sign_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && md[LAT-1] == 2'b01 && rd[LAT-1]) |-> (out_data[DATA_W-1] == dd[LAT-1][DATA_W-1]));

    // R2: logical right by a nonzero distance clears the top bit
    a_r2_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && md[LAT-1][1] == md[LAT-1][0] && rd[LAT-1] && !zd[LAT-1]) |-> !out_data[DATA_W-1]);

    // R1: any left non-rotate by a nonzero distance clears bit 0
    a_r1_bottom_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && md[LAT-1] != 2'b10 && !rd[LAT-1] && !zd[LAT-1]) |-> !out_data[0]);

endmodule

bind log_shift_pipe log_shift_pipe_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_amt    (in_amt),
    .in_dir    (in_dir),
    .in_mode   (in_mode),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/tb_log_shift_pipe.sv
// Bench for log_shift_pipe: a hand-worked vector table streamed back to
// back, a pseudo-random mixed stream with gaps, then reset corner cases.
module tb_log_shift_pipe;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 32;
    localparam int LAT        = 5;
    localparam int N_VEC      = 18;
    localparam int WATCHDOG   = 20000;

    // {req[3:0], mode[1:0], dir, amt[4:0], data[31:0], expected[31:0]}
    localparam logic [75:0] VEC [N_VEC] = '{
        {4'd1, 2'b00, 1'b0, 5'd31, 32'h0000_0001, 32'h8000_0000}, // R1
        {4'd1, 2'b00, 1'b0, 5'd4,  32'hF000_000F, 32'h0000_00F0}, // R1
        {4'd2, 2'b00, 1'b1, 5'd31, 32'h8000_0000, 32'h0000_0001}, // R2
        {4'd2, 2'b00, 1'b1, 5'd4,  32'hF000_000F, 32'h0F00_0000}, // R2
        {4'd3, 2'b01, 1'b1, 5'd31, 32'h8000_0000, 32'hFFFF_FFFF}, // R3
        {4'd3, 2'b01, 1'b1, 5'd4,  32'h8000_0010, 32'hF800_0001}, // R3
        {4'd3, 2'b01, 1'b1, 5'd16, 32'h7FFF_FFFF, 32'h0000_7FFF}, // R3
        {4'd3, 2'b01, 1'b0, 5'd4,  32'h8000_0010, 32'h0000_0100}, // R3
        {4'd4, 2'b10, 1'b0, 5'd4,  32'h1234_5678, 32'h2345_6781}, // R4
        {4'd4, 2'b10, 1'b1, 5'd4,  32'h1234_5678, 32'h8123_4567}, // R4
        {4'd4, 2'b10, 1'b0, 5'd1,  32'hA5A5_A5A5, 32'h4B4B_4B4B}, // R4
        {4'd4, 2'b10, 1'b1, 5'd1,  32'h8000_0001, 32'hC000_0000}, // R4
        {4'd4, 2'b10, 1'b0, 5'd16, 32'h1234_5678, 32'h5678_1234}, // R4
        {4'd5, 2'b10, 1'b1, 5'd0,  32'hDEAD_BEEF, 32'hDEAD_BEEF}, // R5
        {4'd5, 2'b01, 1'b1, 5'd0,  32'hDEAD_BEEF, 32'hDEAD_BEEF}, // R5
        {4'd5, 2'b00, 1'b0, 5'd0,  32'hDEAD_BEEF, 32'hDEAD_BEEF}, // R5
        {4'd8, 2'b11, 1'b0, 5'd8,  32'h0000_00FF, 32'h0000_FF00}, // R8
        {4'd8, 2'b11, 1'b1, 5'd8,  32'h0000_FF00, 32'h0000_00FF}  // R8
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [W-1:0] in_data = '0;
    logic [4:0]   in_amt = '0;
    logic         in_dir = 1'b0;
    logic [1:0]   in_mode = 2'b00;
    logic         out_valid;
    logic [W-1:0] out_data;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    logic [W-1:0] exp_q [$];
    int           cyc_q [$];
    int           req_q [$];

    log_shift_pipe dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_amt    (in_amt),
        .in_dir    (in_dir),
        .in_mode   (in_mode),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WATCHDOG) begin
            errors++;
            $display("FAIL watchdog: run hung at cycle %0d", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Reference model built from the requirement text.
    function automatic logic [W-1:0] ref_shift(input logic [W-1:0] d, input int n,
                                               input logic dir, input logic [1:0] m);
        if (m == 2'b10)
            return dir ? ((d >> n) | (d << (W - n))) : ((d << n) | (d >> (W - n)));
        if (m == 2'b01 && dir)
            return $unsigned($signed(d) >>> n);
        return dir ? (d >> n) : (d << n);
    endfunction

    task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                         input logic [W-1:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    // Result monitor: pops one expectation per flagged result.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R7 unexpected out_valid", 32'd1, 32'd0);
            end else begin
                logic [W-1:0] e;
                int ic;
                int rq;
                e  = exp_q.pop_front();
                ic = cyc_q.pop_front();
                rq = req_q.pop_front();
                check(out_data == e, $sformatf("R%0d data", rq), out_data, e);
                check(cyc - ic == LAT, "R6 latency", W'(cyc - ic), W'(LAT));
            end
        end
    end

    task automatic send(input logic [W-1:0] d, input logic [4:0] n, input logic dir,
                        input logic [1:0] m, input logic [W-1:0] e, input int rq);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = d;
        in_amt   = n;
        in_dir   = dir;
        in_mode  = m;
        exp_q.push_back(e);
        cyc_q.push_back(cyc);
        req_q.push_back(rq);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    initial begin
        logic [W-1:0] lfsr;
        lfsr = 32'h1ACE_B00C;

        // Reset state (R7)
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R7 reset state", W'(out_valid), 32'd0);
        rst_n = 1'b1;
        idle(2);
        check(out_valid == 1'b0, "R7 idle after reset", W'(out_valid), 32'd0);

        // Hand-worked table, streamed back to back (R1-R5, R8 and R6)
        for (int v = 0; v < N_VEC; v++) begin
            send(VEC[v][63:32], VEC[v][68:64], VEC[v][69], VEC[v][71:70],
                 VEC[v][31:0], int'(VEC[v][75:72]));
        end
        idle(LAT + 3);
        check(exp_q.size() == 0, "R6 table drained", W'(exp_q.size()), 32'd0);

        // Mixed random stream with occasional gaps (R6, R7)
        for (int i = 0; i < 400; i++) begin
            logic [1:0] m;
            logic [4:0] n;
            logic       dir;
            lfsr = lfsr ^ (lfsr << 13);
            lfsr = lfsr ^ (lfsr >> 17);
            lfsr = lfsr ^ (lfsr << 5);
            m   = lfsr[1:0];
            n   = lfsr[8:4];
            dir = lfsr[9];
            if (lfsr[15:13] == 3'd0) begin
                idle(1);
            end else begin
                logic [W-1:0] d;
                d = lfsr ^ {lfsr[15:0], lfsr[31:16]};
                send(d, n, dir, m, ref_shift(d, int'(n), dir, m), 6);
            end
        end
        idle(LAT + 3);
        check(exp_q.size() == 0, "R6 stream drained", W'(exp_q.size()), 32'd0);

        // Reset with operands in flight: none may emerge (R7)
        send(32'h0000_0F0F, 5'd3, 1'b0, 2'b00, 32'h0, 7);
        send(32'h0000_0F0F, 5'd3, 1'b1, 2'b10, 32'h0, 7);
        send(32'h0000_0F0F, 5'd3, 1'b1, 2'b01, 32'h0, 7);
        @(negedge clk);
        in_valid = 1'b0;
        rst_n    = 1'b0;
        exp_q.delete();
        cyc_q.delete();
        req_q.delete();
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < LAT + 1; i++) begin
            @(negedge clk);
            check(out_valid == 1'b0, "R7 flushed by reset", W'(out_valid), 32'd0);
        end

        // Distance 31 in each direction after reset, all stages selected (R1, R2)
        send(32'hFFFF_FFFF, 5'd31, 1'b0, 2'b00, 32'h8000_0000, 1);
        send(32'hFFFF_FFFF, 5'd31, 1'b1, 2'b00, 32'h0000_0001, 2);
        send(32'hFFFF_FFFF, 5'd31, 1'b0, 2'b10, 32'hFFFF_FFFF, 4);
        idle(LAT + 3);
        check(exp_q.size() == 0, "R6 final drained", W'(exp_q.size()), 32'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule